// File: doc/BRIEF.md
# Out-of-Order Completion Ring with In-Order Retirement

This block manages a circular buffer of command slots through three running indices. The write index hands out slots in bulk on an allocate request. The dispatch index walks behind it, one slot per advance, to hand slots to execution in order. The read index retires slots. Executed slots may report completion in any order. Each slot holds a completion flag and a header-valid marker, and the read index only moves across an unbroken run of completed slots starting at its current position.

A producer asks for up to a ring's worth of slots and is granted as many as are free. A consumer steps the dispatch index while slots are pending. Execution units report finished slots by index. Each retirement raises a one-cycle pulse so that the new read position can be published to whoever fills the ring. All indices carry one extra wrap bit, which tells a full ring from an empty one.

Top module: `ooo_ring_retire`

## Requirements
- R1: After reset the write, dispatch and read indices are zero, the free count equals the ring depth, no dispatch is pending, every header-valid bit is clear and the retire pulse is low.
- R2: In the same cycle as an allocate request, the grant equals the smaller of the requested count and the free count, and is zero without a request or with a full ring. On the next clock edge the write index advances by the grant.
- R3: Every slot covered by a grant has its header-valid bit set from the next cycle on. A retired slot has it cleared from the cycle in which the read index passes it.
- R4: Dispatch-pending is high exactly when the dispatch index differs from the write index. An advance moves the dispatch index by one when dispatch is pending and is ignored otherwise.
- R5: A completion report is accepted for any slot between the read index (inclusive) and the dispatch index (exclusive), in any order. A report naming any other slot is ignored and never lets the read index pass that slot.
- R6: The read index advances by one slot per cycle while the slot it points at has its completion flag set, clearing that flag as it does so, and stops at the first slot without one. A completion at the read index moves it two clock edges after the report.
- R7: The retire pulse is high for exactly the cycles in which the read index shows a value one greater than in the previous cycle.
- R8: A completion reported while a retirement run is in progress is kept, and is retired when the run reaches that slot.
- R9: The free count always equals the depth minus the distance from the read index to the write index, in modulo-2×depth index arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_req | input | 1 | Allocate request |
| alloc_cnt | input | AW+1 | Number of slots requested |
| alloc_grant | output | AW+1 | Slots granted this cycle (combinational) |
| disp_adv | input | 1 | Step the dispatch index |
| cmpl_vld | input | 1 | Completion report valid |
| cmpl_idx | input | AW | Slot whose work completed |
| free_cnt | output | AW+1 | Free slots |
| disp_pending | output | 1 | Dispatch index behind write index |
| disp_idx | output | AW+1 | Dispatch index with wrap bit |
| rd_idx | output | AW+1 | Read index with wrap bit, for publication |
| retire_pulse | output | 1 | Read index moved by one this cycle |
| hdr_vld | output | DEPTH | Header-valid marker per slot |

## Verification
The grant is combinational, so it is sampled one time unit after the inputs are driven on the falling edge, within the same cycle. Index, free-count, header and pending outputs move on the next rising edge and are compared at the falling edge that follows. A completion at the read index shows up as a moved read index and a retire pulse one cycle later than the completion flag itself, which makes two rising edges after the report. The bench reference model steps once per rising edge in the same order, so every comparison falls in the cycle in which the result is due.

// File: rtl/ooo_ring_pkg.sv
package ooo_ring_pkg;
  function automatic int unsigned umin(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/ring_alloc.sv
module ring_alloc #(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int IW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             alloc_req,
  input  logic [IW-1:0]    alloc_cnt,
  input  logic [IW-1:0]    rd_ptr,
  input  logic             ret_en,
  input  logic [AW-1:0]    ret_slot,
  output logic [IW-1:0]    alloc_grant,
  output logic [IW-1:0]    wr_ptr,
  output logic [IW-1:0]    free_cnt,
  output logic [DEPTH-1:0] hdr_vld
);
  import ooo_ring_pkg::*;
  localparam logic [IW-1:0] DEPTH_W = IW'(DEPTH);

  logic [IW-1:0]    wr_q, wr_n;
  logic [DEPTH-1:0] hdr_q, hdr_n;
  logic [IW-1:0]    used;

  always_comb begin
    used        = wr_q - rd_ptr;
    free_cnt    = DEPTH_W - used;
    alloc_grant = alloc_req ? IW'(umin(int'(alloc_cnt), int'(free_cnt))) : '0;
    wr_n        = wr_q + alloc_grant;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_hdr
    logic [AW-1:0] off;
    logic          set_i;
    logic          clr_i;
    assign off      = AW'(i) - wr_q[AW-1:0];
    assign set_i    = ({1'b0, off} < alloc_grant);
    assign clr_i    = ret_en && (ret_slot == AW'(i));
    assign hdr_n[i] = clr_i ? 1'b0 : (set_i ? 1'b1 : hdr_q[i]);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      hdr_q <= '0;
    end else begin
      wr_q  <= wr_n;
      hdr_q <= hdr_n;
    end
  end

  assign wr_ptr  = wr_q;
  assign hdr_vld = hdr_q;

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_ptr - rd_ptr) <= DEPTH_W);
  p_grant_marks_hdr_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (alloc_grant != '0) |=> hdr_vld[$past(wr_ptr[AW-1:0])]);
  p_grant_bounded_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (alloc_grant <= alloc_cnt) && (alloc_grant <= free_cnt));
endmodule

// File: rtl/ring_dispatch.sv
module ring_dispatch #(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int IW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          disp_adv,
  input  logic [IW-1:0] wr_ptr,
  output logic [IW-1:0] disp_ptr,
  output logic          disp_pending
);
  localparam logic [IW-1:0] DEPTH_W = IW'(DEPTH);

  logic [IW-1:0] disp_q, disp_n;
  logic          step;

  always_comb begin
    disp_pending = (disp_q != wr_ptr);
    step         = disp_adv && disp_pending;
    disp_n       = step ? disp_q + IW'(1) : disp_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) disp_q <= '0;
    else         disp_q <= disp_n;
  end

  assign disp_ptr = disp_q;

  p_idle_adv_ignored_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (disp_adv && !disp_pending) |=> $stable(disp_ptr));
  p_disp_behind_wr_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_ptr - disp_ptr) <= DEPTH_W);
endmodule

// File: rtl/ring_retire.sv
module ring_retire #(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int IW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          cmpl_vld,
  input  logic [AW-1:0] cmpl_idx,
  input  logic [IW-1:0] disp_ptr,
  output logic [IW-1:0] rd_ptr,
  output logic          ret_en,
  output logic [AW-1:0] ret_slot,
  output logic          retire_pulse
);
  localparam logic [IW-1:0] DEPTH_W = IW'(DEPTH);

  logic [DEPTH-1:0] flag_q, flag_n;
  logic [IW-1:0]    rd_q, rd_n;
  logic             pulse_q;
  logic [AW-1:0]    rd_slot;
  logic [IW-1:0]    inflight;
  logic [AW-1:0]    off;
  logic             accept;

  always_comb begin
    rd_slot  = rd_q[AW-1:0];
    ret_en   = flag_q[rd_slot] && (rd_q != disp_ptr);
    inflight = disp_ptr - rd_q;
    off      = cmpl_idx - rd_slot;
    accept   = cmpl_vld && ({1'b0, off} < inflight) && !(ret_en && (cmpl_idx == rd_slot));
    rd_n     = ret_en ? rd_q + IW'(1) : rd_q;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_flag
    logic set_i;
    logic clr_i;
    assign set_i     = accept && (cmpl_idx == AW'(i));
    assign clr_i     = ret_en && (rd_slot == AW'(i));
    assign flag_n[i] = set_i ? 1'b1 : (clr_i ? 1'b0 : flag_q[i]);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= '0;
      rd_q    <= '0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= flag_n;
      rd_q    <= rd_n;
      pulse_q <= ret_en;
    end
  end

  assign rd_ptr       = rd_q;
  assign ret_slot     = rd_slot;
  assign retire_pulse = pulse_q;

  p_pulse_one_step_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    retire_pulse |-> (rd_ptr == $past(rd_ptr) + IW'(1)));
  p_stop_at_gap_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !flag_q[rd_ptr[AW-1:0]] |=> $stable(rd_ptr));
  p_rd_behind_disp_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (disp_ptr - rd_ptr) <= DEPTH_W);
  p_flag_cleared_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    ret_en |=> !flag_q[$past(ret_slot)]);
endmodule

// File: rtl/ooo_ring_retire.sv
module ooo_ring_retire #(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int IW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic [IW-1:0]    alloc_cnt,
  output logic [IW-1:0]    alloc_grant,
  input  logic             disp_adv,
  input  logic             cmpl_vld,
  input  logic [AW-1:0]    cmpl_idx,
  output logic [IW-1:0]    free_cnt,
  output logic             disp_pending,
  output logic [IW-1:0]    disp_idx,
  output logic [IW-1:0]    rd_idx,
  output logic             retire_pulse,
  output logic [DEPTH-1:0] hdr_vld
);
  logic [1:0]    rst_sync;
  logic          rst_ni;
  logic [IW-1:0] wr_ptr;
  logic [IW-1:0] disp_ptr;
  logic [IW-1:0] rd_ptr;
  logic          ret_en;
  logic [AW-1:0] ret_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  ring_alloc #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_alloc (
    .clk(clk), .rst_ni(rst_ni), .alloc_req(alloc_req), .alloc_cnt(alloc_cnt),
    .rd_ptr(rd_ptr), .ret_en(ret_en), .ret_slot(ret_slot),
    .alloc_grant(alloc_grant), .wr_ptr(wr_ptr), .free_cnt(free_cnt), .hdr_vld(hdr_vld)
  );

  ring_dispatch #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_disp (
    .clk(clk), .rst_ni(rst_ni), .disp_adv(disp_adv), .wr_ptr(wr_ptr),
    .disp_ptr(disp_ptr), .disp_pending(disp_pending)
  );

  ring_retire #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_ret (
    .clk(clk), .rst_ni(rst_ni), .cmpl_vld(cmpl_vld), .cmpl_idx(cmpl_idx),
    .disp_ptr(disp_ptr), .rd_ptr(rd_ptr), .ret_en(ret_en), .ret_slot(ret_slot),
    .retire_pulse(retire_pulse)
  );

  assign disp_idx = disp_ptr;
  assign rd_idx   = rd_ptr;

  p_free_matches_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (free_cnt + (wr_ptr - rd_ptr)) == IW'(DEPTH));
  p_pending_vs_wr_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    disp_pending == (disp_idx != wr_ptr));
endmodule

// File: tb/ooo_ring_retire_test.sv
`timescale 1ns/1ps
module ooo_ring_retire_test;
  localparam int D  = 8;
  localparam int AW = 3;
  localparam int IW = 4;
  localparam int M2 = 2 * D;
  localparam int WATCHDOG_CYC = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_req = 1'b0;
  logic [IW-1:0] alloc_cnt = '0;
  logic          disp_adv = 1'b0;
  logic          cmpl_vld = 1'b0;
  logic [AW-1:0] cmpl_idx = '0;
  logic [IW-1:0] alloc_grant, free_cnt, disp_idx, rd_idx;
  logic          disp_pending, retire_pulse;
  logic [D-1:0]  hdr_vld;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int m_wr = 0, m_rd = 0, m_disp = 0;
  bit m_ret = 0;
  bit m_flag [D];
  bit m_hdr  [D];

  always #10 clk = ~clk;

  ooo_ring_retire #(.DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_cnt(alloc_cnt),
    .alloc_grant(alloc_grant), .disp_adv(disp_adv), .cmpl_vld(cmpl_vld),
    .cmpl_idx(cmpl_idx), .free_cnt(free_cnt), .disp_pending(disp_pending),
    .disp_idx(disp_idx), .rd_idx(rd_idx), .retire_pulse(retire_pulse), .hdr_vld(hdr_vld)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_free();
    return D - ((m_wr - m_rd + M2) % M2);
  endfunction

  function automatic int m_grant(input bit req, input int cnt);
    int f = m_free();
    if (!req) return 0;
    return (cnt < f) ? cnt : f;
  endfunction

  function automatic int m_hdr_vec();
    int v = 0;
    for (int i = 0; i < D; i++) if (m_hdr[i]) v |= (1 << i);
    return v;
  endfunction

  task automatic model_step(input bit req, input int cnt, input bit adv,
                            input bit cv, input int idx);
    int g     = m_grant(req, cnt);
    int rslot = m_rd % D;
    bit ret   = m_flag[rslot] && (m_rd != m_disp);
    int infl  = (m_disp - m_rd + M2) % M2;
    int off   = (idx - rslot + D) % D;
    bit acc   = cv && (off < infl) && !(ret && idx == rslot);
    for (int k = 0; k < g; k++) m_hdr[(m_wr + k) % D] = 1;
    if (ret) begin
      m_flag[rslot] = 0;
      m_hdr[rslot]  = 0;
      m_rd = (m_rd + 1) % M2;
    end
    if (acc) m_flag[idx] = 1;
    if (adv && (m_disp != m_wr)) m_disp = (m_disp + 1) % M2;
    m_wr  = (m_wr + g) % M2;
    m_ret = ret;
  endtask

  // Called at a falling edge: compare registered outputs, drive, check grant, advance.
  task automatic cyc(input bit req, input int cnt, input bit adv, input bit cv, input int idx);
    chk("R9 free_cnt", int'(free_cnt), m_free());
    chk("R2 write side via free", int'(free_cnt) + ((m_wr - int'(rd_idx) + M2) % M2), D);
    chk("R4 disp_pending", int'(disp_pending), int'(m_disp != m_wr));
    chk("R4 disp_idx", int'(disp_idx), m_disp);
    chk("R6 rd_idx", int'(rd_idx), m_rd);
    chk("R7 retire_pulse", int'(retire_pulse), int'(m_ret));
    chk("R3 hdr_vld", int'(hdr_vld), m_hdr_vec());
    alloc_req = req; alloc_cnt = IW'(cnt); disp_adv = adv;
    cmpl_vld = cv; cmpl_idx = AW'(idx);
    #1;
    chk("R2 alloc_grant", int'(alloc_grant), m_grant(req, cnt));
    @(posedge clk);
    model_step(req, cnt, adv, cv, idx);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < D; i++) begin m_flag[i] = 0; m_hdr[i] = 0; end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rd_idx", int'(rd_idx), 0);
    chk("R1 disp_idx", int'(disp_idx), 0);
    chk("R1 free_cnt", int'(free_cnt), D);
    chk("R1 disp_pending", int'(disp_pending), 0);
    chk("R1 hdr_vld", int'(hdr_vld), 0);
    chk("R1 retire_pulse", int'(retire_pulse), 0);

    // R4: advance with nothing pending is ignored
    cyc(0, 0, 1, 0, 0);
    chk("R4 idle advance", int'(disp_idx), 0);
    // R2: request 5, then 5 more with only 3 free, then request on full ring
    cyc(1, 5, 0, 0, 0);
    chk("R2 after first grant", int'(free_cnt), 3);
    cyc(1, 5, 0, 0, 0);
    chk("R2 clipped to free", int'(free_cnt), 0);
    cyc(1, 4, 0, 0, 0);
    // R5: completion of undispatched slot 0 is ignored
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 1, 0, 0);
    idle(2);
    chk("R5 undispatched ignored", int'(rd_idx), 0);
    // dispatch five more (six in flight)
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 0);
    // R5 out of order: 2,1,4 then 0 starts a run; 3 and 5 arrive during it (R8)
    cyc(0, 0, 0, 1, 2);
    cyc(0, 0, 0, 1, 1);
    cyc(0, 0, 0, 1, 4);
    idle(1);
    chk("R6 blocked at head", int'(rd_idx), 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 3);
    cyc(0, 0, 0, 1, 5);
    idle(8);
    chk("R8 run absorbed late completions", int'(rd_idx), 6);
    chk("R3 retired headers cleared", int'(hdr_vld), 8'hC0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit req = ($urandom_range(0, 99) < 35);
      int cnt = $urandom_range(0, D);
      bit adv = ($urandom_range(0, 99) < 55);
      bit cv  = ($urandom_range(0, 99) < 65);
      int idx;
      int infl = (m_disp - m_rd + M2) % M2;
      if (infl > 0 && $urandom_range(0, 99) < 80)
        idx = (m_rd + $urandom_range(0, infl - 1)) % D;
      else
        idx = $urandom_range(0, D - 1);
      cyc(req, cnt, adv, cv, idx);
    end
    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule